// File: doc/BRIEF.md
# Periodic Tick Timer with Wait Stall and Watchdog

This block divides the processor clock down to a slow periodic tick, about 76 Hz from a clock near 5 MHz in the default setting. The same tick serves two purposes. It releases a processor that has executed a wait-for-tick operation. It also advances a watchdog that counts ticks passing without a kick. The kick is a strobe that the processor raises as a side effect of one particular add operation.

When the programmed number of ticks passes without a kick, the block drives a processor reset pulse of fixed length, so that execution restarts at address zero. During that pulse the block abandons any pending wait and ignores its inputs. After the pulse it begins counting missed ticks again from zero. The divider ratio is a parameter, so a test can use a short tick period. The external reset is asynchronous and active low, and the block releases it internally through a two-stage synchronizer.

Top module: `tick_watchdog`

## Requirements
- R1: `tick` is high for exactly one cycle out of every DIV_RATIO cycles. The divider starts counting on the third rising edge after `rst_n` goes high, and the first tick appears DIV_RATIO-1 edges later. A watchdog reset does not disturb the divider.
- R2: While `rst_n` is low, and for two edges after it rises, `stall`, `tick` and `wdog_rst` are all low.
- R3: A one-cycle `wait_req` sampled while not stalling raises `stall` on the next cycle. `stall` stays high up to and including the next cycle in which `tick` is high, and drops on the cycle after that.
- R4: A `wait_req` sampled while `stall` is already high has no effect. A `wait_req` sampled in a tick cycle while not stalling waits for the following tick, not the current one.
- R5: A `kick` clears the count of missed ticks. While at least one kick arrives between any MISS_LIMIT consecutive ticks, `wdog_rst` stays low.
- R6: The MISS_LIMIT-th consecutive tick without a kick makes `wdog_rst` go high on the next cycle. It stays high for exactly RST_CYCLES cycles.
- R7: A `kick` in the same cycle as a tick wins, so the missed-tick count is zero afterwards. Only MISS_LIMIT further unkicked ticks can then fire the watchdog.
- R8: While `wdog_rst` is high, `stall` is low on the following cycle. In that window `wait_req` and `kick` have no effect and ticks are not counted. After the pulse, MISS_LIMIT fresh unkicked ticks are needed to fire again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wait_req | input | 1 | One-cycle strobe from a wait-for-tick operation |
| kick | input | 1 | One-cycle watchdog kick from the add-with-kick operation |
| stall | output | 1 | High while the processor must hold for a tick |
| tick | output | 1 | One-cycle periodic tick pulse |
| wdog_rst | output | 1 | Processor reset pulse from a watchdog timeout |

## Verification
A divider count that is off appears at `tick` within one period as a shifted or missing pulse. It then shows up as a stall that releases early or late. A corrupted missed-tick count shows at `wdog_rst`, which fires one tick early or late or not at all. That is visible within MISS_LIMIT tick periods of the last kick. A wrong priority between kick and tick, or ticks counted during the reset pulse, moves the next reset pulse by a whole tick period. The bench therefore compares all three outputs against a behavioural model on every cycle across several kick and wait patterns.

// File: rtl/tickdog_pkg.sv
package tickdog_pkg;

  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_WAIT = 1'b1
  } stall_state_e;

  // bit width needed to hold values 0 .. n-1, at least one bit
  function automatic int unsigned span_bits(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/tdg_rst_sync.sv
module tdg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sn = stage2_q;

endmodule

// File: rtl/tdg_divider.sv
module tdg_divider #(
  parameter int unsigned DIV_RATIO = 65789
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  import tickdog_pkg::*;

  localparam int unsigned CNT_W = span_bits(DIV_RATIO);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV_RATIO - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             at_last;

  assign at_last = (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (at_last) cnt_d = '0;
    else         cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = at_last;

  // R1: a tick never lasts more than one cycle
  p_single_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);

  // R1: the count never leaves its range
  p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

endmodule

// File: rtl/tdg_stall.sv
module tdg_stall (
  input  logic clk,
  input  logic rst_n,
  input  logic wait_req_i,
  input  logic tick_i,
  input  logic hold_i,
  output logic stall_o
);
  import tickdog_pkg::*;

  stall_state_e st_q;
  stall_state_e st_d;

  always_comb begin
    st_d = st_q;
    if (hold_i) begin
      st_d = ST_RUN;
    end else begin
      case (st_q)
        ST_RUN:  if (wait_req_i) st_d = ST_WAIT;
        ST_WAIT: if (tick_i)     st_d = ST_RUN;
        default: st_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_RUN;
    else        st_q <= st_d;
  end

  assign stall_o = (st_q == ST_WAIT);

  // R3: a wait request while running raises the stall
  p_stall_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_req_i && !stall_o && !hold_i) |=> stall_o);

  // R3: a tick releases the stall on the next cycle
  p_stall_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_o && tick_i) |=> !stall_o);

  // R4: without a tick the stall holds, whatever wait_req does
  p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_o && !tick_i && !hold_i) |=> stall_o);

  // R8: a watchdog reset drops any pending stall
  p_hold_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> !stall_o);

endmodule

// File: rtl/tdg_watchdog.sv
module tdg_watchdog #(
  parameter int unsigned MISS_LIMIT = 3,
  parameter int unsigned RST_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic kick_i,
  output logic wdog_rst_o
);
  import tickdog_pkg::*;

  localparam int unsigned MISS_W  = span_bits(MISS_LIMIT);
  localparam int unsigned PULSE_W = span_bits(RST_CYCLES + 1);
  localparam logic [MISS_W-1:0]  MISS_TOP   = MISS_W'(MISS_LIMIT - 1);
  localparam logic [PULSE_W-1:0] PULSE_LOAD = PULSE_W'(RST_CYCLES);

  logic [MISS_W-1:0]  miss_q;
  logic [MISS_W-1:0]  miss_d;
  logic [PULSE_W-1:0] pulse_q;
  logic [PULSE_W-1:0] pulse_d;
  logic               active;
  logic               fire;
  logic               miss_en;
  logic               pulse_en;

  assign active = (pulse_q != '0);
  assign fire   = !active && !kick_i && tick_i && (miss_q == MISS_TOP);

  // missed-tick counter: kick wins over tick, reset pulse freezes it at zero
  always_comb begin
    miss_en = active || kick_i || tick_i;
    miss_d  = miss_q;
    if (active || kick_i)        miss_d = '0;
    else if (tick_i) begin
      if (miss_q == MISS_TOP)    miss_d = '0;
      else                       miss_d = miss_q + 1'b1;
    end
  end

  // reset pulse length counter
  always_comb begin
    pulse_en = fire || active;
    pulse_d  = pulse_q;
    if (fire)        pulse_d = PULSE_LOAD;
    else if (active) pulse_d = pulse_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       miss_q <= '0;
    else if (miss_en) miss_q <= miss_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pulse_q <= '0;
    else if (pulse_en) pulse_q <= pulse_d;
  end

  assign wdog_rst_o = active;

  // R5: a kick outside a reset pulse leaves no missed ticks
  p_kick_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (kick_i && !active) |=> (miss_q == '0));

  // R6: a reset pulse starts only on an unkicked tick
  p_fire_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdog_rst_o) |-> ($past(tick_i) && !$past(kick_i)));

  // R7: kick coinciding with a tick cannot start a pulse
  p_kick_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (kick_i && tick_i && !active) |=> (!wdog_rst_o && miss_q == '0));

  // R8: ticks during the pulse are not counted
  p_no_count_in_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> (miss_q == '0));

endmodule

// File: rtl/tick_watchdog.sv
module tick_watchdog #(
  parameter int unsigned DIV_RATIO  = 65789,
  parameter int unsigned MISS_LIMIT = 3,
  parameter int unsigned RST_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wait_req,
  input  logic kick,
  output logic stall,
  output logic tick,
  output logic wdog_rst
);

  logic rst_sn;
  logic tick_w;
  logic wdog_w;

  tdg_rst_sync u_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  tdg_divider #(
    .DIV_RATIO (DIV_RATIO)
  ) u_divider (
    .clk    (clk),
    .rst_n  (rst_sn),
    .tick_o (tick_w)
  );

  tdg_watchdog #(
    .MISS_LIMIT (MISS_LIMIT),
    .RST_CYCLES (RST_CYCLES)
  ) u_watchdog (
    .clk        (clk),
    .rst_n      (rst_sn),
    .tick_i     (tick_w),
    .kick_i     (kick),
    .wdog_rst_o (wdog_w)
  );

  tdg_stall u_stall (
    .clk        (clk),
    .rst_n      (rst_sn),
    .wait_req_i (wait_req),
    .tick_i     (tick_w),
    .hold_i     (wdog_w),
    .stall_o    (stall)
  );

  assign tick     = tick_w;
  assign wdog_rst = wdog_w;

endmodule

// File: tb/test_tick_watchdog.sv
module test_tick_watchdog;

  localparam int DIV   = 10;
  localparam int LIMIT = 3;
  localparam int PULSE = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic wait_req;
  logic kick;
  logic stall;
  logic tick;
  logic wdog_rst;

  int    vectors = 0;
  int    errors  = 0;
  int    cycles  = 0;
  string tag     = "R2";

  // reference model state
  int m_sync  = 0;
  int m_div   = 0;
  int m_wait  = 0;
  int m_miss  = 0;
  int m_pulse = 0;

  always #10 clk = ~clk;

  tick_watchdog #(
    .DIV_RATIO  (DIV),
    .MISS_LIMIT (LIMIT),
    .RST_CYCLES (PULSE)
  ) i_tick_watchdog (
    .clk      (clk),
    .rst_n    (rst_n),
    .wait_req (wait_req),
    .kick     (kick),
    .stall    (stall),
    .tick     (tick),
    .wdog_rst (wdog_rst)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sync = 0; m_div = 0; m_wait = 0; m_miss = 0; m_pulse = 0;
    end else if (m_sync < 2) begin
      m_sync = m_sync + 1;
    end else begin
      bit t, act, fire;
      t    = (m_div == DIV - 1);
      act  = (m_pulse > 0);
      fire = !act && !kick && t && (m_miss == LIMIT - 1);
      m_div = t ? 0 : m_div + 1;
      if (act)             m_wait = 0;
      else if (m_wait == 1) m_wait = t ? 0 : 1;
      else                 m_wait = wait_req ? 1 : 0;
      if (act || kick)     m_miss = 0;
      else if (t)          m_miss = (m_miss == LIMIT - 1) ? 0 : m_miss + 1;
      if (fire)            m_pulse = PULSE;
      else if (act)        m_pulse = m_pulse - 1;
    end
  end

  always @(negedge clk) begin
    logic e_tick, e_stall, e_wdog;
    e_tick  = (m_sync == 2) && (m_div == DIV - 1);
    e_stall = (m_wait == 1);
    e_wdog  = (m_pulse > 0);
    vectors = vectors + 1;
    if (tick !== e_tick) begin
      errors = errors + 1;
      $display("FAIL R1 tick: actual %b expected %b at cycle %0d", tick, e_tick, cycles);
    end
    if (stall !== e_stall) begin
      errors = errors + 1;
      $display("FAIL %s stall: actual %b expected %b at cycle %0d", tag, stall, e_stall, cycles);
    end
    if (wdog_rst !== e_wdog) begin
      errors = errors + 1;
      $display("FAIL %s wdog_rst: actual %b expected %b at cycle %0d", tag, wdog_rst, e_wdog, cycles);
    end
  end

  always @(posedge clk) begin
    cycles = cycles + 1;
    if (cycles > 5000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired: actual %0d cycles expected under 5000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic step(input logic w, input logic k);
    @(negedge clk);
    #1;
    wait_req = w;
    kick     = k;
  endtask

  task automatic to_tick();
    forever begin
      @(negedge clk);
      #1;
      wait_req = 1'b0;
      kick     = 1'b0;
      if (tick) break;
    end
  endtask

  initial begin
    rst_n    = 1'b0;
    wait_req = 1'b0;
    kick     = 1'b0;
    tag      = "R2";
    repeat (3) step(1'b0, 1'b0);
    rst_n = 1'b1;
    repeat (2) step(1'b1, 1'b1);

    // kicks every 8 cycles keep the watchdog quiet
    tag = "R5";
    for (int i = 0; i < 30; i++) step(1'b0, (i % 8) == 7);

    // plain wait released by the next tick
    tag = "R3";
    step(1'b1, 1'b0);
    for (int i = 0; i < 25; i++) step(1'b0, (i % 8) == 7);

    // wait issued in a tick cycle, repeated wait while stalled
    tag = "R4";
    to_tick();
    wait_req = 1'b1;
    step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    for (int i = 0; i < 25; i++) step(1'b0, (i % 8) == 7);

    // kick on the tick cycle, then two unkicked ticks must not fire
    tag = "R7";
    for (int i = 0; i < 8; i++) step(1'b0, 1'b0);
    to_tick();
    kick = 1'b1;
    for (int i = 0; i < 25; i++) step(1'b0, 1'b0);
    step(1'b0, 1'b1);

    // no kicks: timeout while a wait is pending
    tag = "R6";
    step(1'b1, 1'b0);
    for (int i = 0; i < 45; i++) step(1'b0, 1'b0);

    // inputs during the pulse are ignored, then a fresh timeout
    tag = "R8";
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      #1;
      if (wdog_rst) break;
      wait_req = 1'b0;
      kick     = 1'b0;
    end
    for (int i = 0; i < PULSE; i++) begin
      wait_req = 1'b1;
      kick     = 1'b1;
      @(negedge clk);
      #1;
    end
    wait_req = 1'b0;
    kick     = 1'b0;
    for (int i = 0; i < 45; i++) step(1'b0, 1'b0);

    @(negedge clk);
    #1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule